// File: doc/BRIEF.md
# Display Byte Pixel Serializer

This block converts one fetched display byte into a run of on-screen pixels. Each byte can hold eight 1-bit pixels, four 2-bit pixels or two 4-bit pixels. In memory the bits of one multi-bit pixel are spread across the byte. On load, the block regroups them so that each pixel's bits are adjacent. It then emits the pixels most significant first.

Each pixel can be held on screen for 1, 2 or 4 clocks. The hold is set by the horizontal scale and by a one-hot slot phase, which tells which clocks of the eight-clock slot may advance the shifter. A marker register counts how many pixels of the byte are still pending. Each logical pixel value is looked up in a 16-entry palette, which holds its reset defaults, to give a 3-bit RGB colour. The output is black whenever no pixel is pending or the display window is inactive.

The wider display pipeline uses this block as follows. It pulses the load strobe with each fetched byte, holds depth and scale at the values for the current screen mode, and rotates the slot phase one step per clock.

Top module: `pix_serializer`

## Requirements
- R1: After reset, and until the first load strobe, `rgbOut` is 3'b000 even when `activeWin` is 1.
- R2: With `depthSel`=1, a loaded byte gives 8 pixels in the order bit 7 down to bit 0. Each pixel is a 1-bit logical colour.
- R3: With `depthSel`=2, a loaded byte gives 4 pixels. Pixel k (k=0..3) is the 2-bit value {bit(7-k), bit(3-k)}.
- R4: With `depthSel`=4, a loaded byte gives 2 pixels. Pixel k (k=0..1) is the 4-bit value {bit(7-k), bit(5-k), bit(3-k), bit(1-k)}.
- R5: Pixel 0 is visible in the clock after the load edge. The shifter advances at a later clock edge according to `scaleSel`. With 1 it advances at every edge. With 2 it advances only at edges where `slotPhase` has bit 0, 2, 4 or 6 set (mask 8'h55). With 4 it advances only at edges where bit 0 or 4 is set (mask 8'h11).
- R6: Once all pixels of a byte have been shown, `rgbOut` is 3'b000 until the next load.
- R7: The palette maps logical colour i to RGB value i mod 8, with `rgbOut[0]` red, `rgbOut[1]` green and `rgbOut[2]` blue.
- R8: While `activeWin` is 0, `rgbOut` is 3'b000. Pixels keep advancing meanwhile, so the hidden pixels are skipped.
- R9: A `depthSel` other than 1, 2 or 4 acts as depth 1. A `scaleSel` other than 1, 2 or 4 acts as scale 1.
- R10: A load strobe while pixels are still pending discards them and restarts with the new byte's pixel 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadByte | input | 1 | Strobe: capture `byteIn` at this edge |
| byteIn | input | 8 | Fetched display byte |
| depthSel | input | 3 | Bits per pixel: 1, 2 or 4 |
| scaleSel | input | 3 | Clocks per pixel: 1, 2 or 4 |
| slotPhase | input | PHASES | One-hot position within the slot |
| activeWin | input | 1 | Display window is active |
| rgbOut | output | 3 | Colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench uses the default parameters: an eight-phase slot and a 16-entry palette. With these, the real 8'h55 and 8'h11 advance masks apply, and 4-bit logical colours above 7 can show the modulo-8 palette folding. The bench walks the slot phase continuously across byte boundaries, so a byte can start on an odd phase at scale 2 or at any phase at scale 4. This exposes the uneven hold of the first pixel and the skipping of pixels hidden by an inactive window.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    BPP1 = 2'd0,
    BPP2 = 2'd1,
    BPP4 = 2'd2
  } bpp_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ser_strobes_t;

  function automatic bpp_e decode_depth(input logic [2:0] code);
    case (code)
      3'd2:    return BPP2;
      3'd4:    return BPP4;
      default: return BPP1;
    endcase
  endfunction

  // Gather the scattered bits of each pixel into adjacent positions.
  function automatic logic [BYTE_W-1:0] regroup(input logic [BYTE_W-1:0] b,
                                                input bpp_e d);
    case (d)
      BPP2:    return {b[7], b[3], b[6], b[2], b[5], b[1], b[4], b[0]};
      BPP4:    return {b[7], b[5], b[3], b[1], b[6], b[4], b[2], b[0]};
      default: return b;
    endcase
  endfunction

endpackage

// File: rtl/pix_ser_ctrl.sv
module pix_ser_ctrl
  import pix_ser_pkg::*;
#(
  parameter int PHASES = 8,
  parameter logic [PHASES-1:0] HALF_MASK = PHASES'('h55),
  parameter logic [PHASES-1:0] QUARTER_MASK = PHASES'('h11)
) (
  input  logic              loadByte,
  input  logic [2:0]        scaleSel,
  input  logic [PHASES-1:0] slotPhase,
  input  logic              pixPending,
  output ser_strobes_t      strb
);

  logic stepOk;

  always_comb begin
    case (scaleSel)
      3'd2:    stepOk = |(slotPhase & HALF_MASK);
      3'd4:    stepOk = |(slotPhase & QUARTER_MASK);
      default: stepOk = 1'b1;
    endcase
  end

  always_comb begin
    strb.load    = loadByte;
    strb.advance = pixPending && !loadByte && stepOk;
  end

endmodule

// File: rtl/pix_ser_datapath.sv
module pix_ser_datapath
  import pix_ser_pkg::*;
#(
  parameter int PAL_DEPTH = 16,
  parameter int RGB_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ser_strobes_t      strb,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic [2:0]        depthSel,
  input  logic              activeWin,
  output logic              pixPending,
  output logic [RGB_W-1:0]  rgbOut
);

  localparam int IDX_W = $clog2(PAL_DEPTH);

  logic [BYTE_W-1:0] shiftQ;
  logic [BYTE_W-1:0] markQ;
  bpp_e              depthQ;
  logic [IDX_W-1:0]  pixVal;
  logic [RGB_W-1:0]  palette [PAL_DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      markQ  <= '0;
      depthQ <= BPP1;
    end else if (strb.load) begin
      shiftQ <= regroup(byteIn, decode_depth(depthSel));
      markQ  <= BYTE_W'(1);
      depthQ <= decode_depth(depthSel);
    end else if (strb.advance) begin
      case (depthQ)
        BPP2: begin
          shiftQ <= {shiftQ[BYTE_W-3:0], shiftQ[BYTE_W-1 -: 2]};
          markQ  <= {markQ[BYTE_W-3:0], 2'b00};
        end
        BPP4: begin
          shiftQ <= {shiftQ[BYTE_W-5:0], shiftQ[BYTE_W-1 -: 4]};
          markQ  <= {markQ[BYTE_W-5:0], 4'b0000};
        end
        default: begin
          shiftQ <= {shiftQ[BYTE_W-2:0], shiftQ[BYTE_W-1]};
          markQ  <= {markQ[BYTE_W-2:0], 1'b0};
        end
      endcase
    end
  end

  // Palette entries reset to the identity-modulo-colour-count map.
  for (genvar i = 0; i < PAL_DEPTH; i++) begin : g_pal
    always_ff @(posedge clk) begin
      if (!rstN) palette[i] <= RGB_W'(i);
    end
  end

  always_comb begin
    case (depthQ)
      BPP2:    pixVal = IDX_W'(shiftQ[BYTE_W-1 -: 2]);
      BPP4:    pixVal = IDX_W'(shiftQ[BYTE_W-1 -: 4]);
      default: pixVal = IDX_W'(shiftQ[BYTE_W-1]);
    endcase
  end

  assign pixPending = |markQ;
  assign rgbOut = (pixPending && activeWin) ? palette[pixVal] : '0;

endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int PHASES = 8,
  parameter int PAL_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadByte,
  input  logic [7:0]        byteIn,
  input  logic [2:0]        depthSel,
  input  logic [2:0]        scaleSel,
  input  logic [PHASES-1:0] slotPhase,
  input  logic              activeWin,
  output logic [2:0]        rgbOut
);

  ser_strobes_t ctrlStrb;
  logic         pixPending;

  pix_ser_ctrl #(.PHASES(PHASES)) i_ctrl (
    .loadByte  (loadByte),
    .scaleSel  (scaleSel),
    .slotPhase (slotPhase),
    .pixPending(pixPending),
    .strb      (ctrlStrb)
  );

  pix_ser_datapath #(.PAL_DEPTH(PAL_DEPTH), .RGB_W(3)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (ctrlStrb),
    .byteIn    (byteIn),
    .depthSel  (depthSel),
    .activeWin (activeWin),
    .pixPending(pixPending),
    .rgbOut    (rgbOut)
  );

endmodule

// File: rtl/pix_ser_checker.sv
module pix_ser_checker
  import pix_ser_pkg::*;
#(
  parameter int PHASES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadByte,
  input logic [2:0]        scaleSel,
  input logic [PHASES-1:0] slotPhase,
  input logic              activeWin,
  input logic [2:0]        rgbOut,
  input ser_strobes_t      ctrlStrb,
  input logic              pixPending
);

  assert_black_inactive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !activeWin |-> rgbOut == 3'b000);

  assert_black_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pixPending |-> rgbOut == 3'b000);

  assert_load_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    loadByte |=> pixPending);

  assert_half_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (scaleSel == 3'd2 && (slotPhase & PHASES'('h55)) == '0) |-> !ctrlStrb.advance);

  assert_quarter_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (scaleSel == 3'd4 && (slotPhase & PHASES'('h11)) == '0) |-> !ctrlStrb.advance);

endmodule

bind pix_serializer pix_ser_checker #(.PHASES(PHASES)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadByte  (loadByte),
  .scaleSel  (scaleSel),
  .slotPhase (slotPhase),
  .activeWin (activeWin),
  .rgbOut    (rgbOut),
  .ctrlStrb  (ctrlStrb),
  .pixPending(pixPending)
);

// File: tb/test_pix_serializer.sv
module test_pix_serializer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadByte = 1'b0;
  logic [7:0] byteIn = '0;
  logic [2:0] depthSel = 3'd1;
  logic [2:0] scaleSel = 3'd1;
  logic [7:0] slotPhase = 8'd1;
  logic       activeWin = 1'b1;
  logic [2:0] rgbOut;

  int checks = 0;
  int errors = 0;
  int phaseIdx = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_serializer i_pix_serializer (
    .clk(clk), .rstN(rstN), .loadByte(loadByte), .byteIn(byteIn),
    .depthSel(depthSel), .scaleSel(scaleSel), .slotPhase(slotPhase),
    .activeWin(activeWin), .rgbOut(rgbOut)
  );

  function automatic int effDepth(input logic [2:0] code);
    if (code == 3'd2) return 2;
    if (code == 3'd4) return 4;
    return 1;
  endfunction

  function automatic bit stepAllowed(input logic [2:0] sc, input int ph);
    if (sc == 3'd2) return (ph % 2) == 0;
    if (sc == 3'd4) return (ph % 4) == 0;
    return 1'b1;
  endfunction

  function automatic logic [3:0] pixelOf(input logic [7:0] b, input int d, input int k);
    if (d == 2) return {2'b00, b[7-k], b[3-k]};
    if (d == 4) return {b[7-k], b[5-k], b[3-k], b[1-k]};
    return {3'b000, b[7-k]};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if (rgbOut !== exp) begin
      errors++;
      $display("FAIL %s: rgbOut=%b expected=%b at %0t", tag, rgbOut, exp, $time);
    end
  endtask

  // Load a byte, then run nCycles clocks checking every pixel.
  // activeOff: cycle index during which activeWin is low (-1: never).
  task automatic playByte(input string tag, input logic [7:0] b, input logic [2:0] dc,
                          input logic [2:0] sc, input int nCycles, input int activeOff);
    int d, cnt, idx;
    logic [2:0] exp;
    d = effDepth(dc);
    cnt = 8 / d;
    loadByte = 1'b1; byteIn = b; depthSel = dc; scaleSel = sc;
    @(negedge clk);
    loadByte = 1'b0;
    idx = 0;
    for (int c = 0; c < nCycles; c++) begin
      activeWin = (c != activeOff);
      #1;
      exp = (activeWin && idx < cnt) ? pixelOf(b, d, idx)[2:0] : 3'b000;
      check(tag, exp);
      phaseIdx = (phaseIdx + 1) % 8;
      slotPhase = 8'(1 << phaseIdx);
      if (idx < cnt && stepAllowed(sc, phaseIdx)) idx++;
      @(negedge clk);
    end
    activeWin = 1'b1;
  endtask

  task automatic testReset();
    for (int c = 0; c < 4; c++) begin
      #1 check("R1", 3'b000);
      phaseIdx = (phaseIdx + 1) % 8;
      slotPhase = 8'(1 << phaseIdx);
      @(negedge clk);
    end
  endtask

  task automatic testDepth1();
    playByte("R2", 8'hA5, 3'd1, 3'd1, 8, -1);
    playByte("R6", 8'hFF, 3'd1, 3'd1, 12, -1);
  endtask

  task automatic testDepth2();
    playByte("R3", 8'h6C, 3'd2, 3'd1, 6, -1);
    playByte("R3", 8'h93, 3'd2, 3'd2, 12, -1);
  endtask

  task automatic testDepth4();
    playByte("R4", 8'h5A, 3'd4, 3'd4, 12, -1);
    playByte("R7", 8'hFF, 3'd4, 3'd1, 4, -1);
    playByte("R7", 8'hAA, 3'd4, 3'd2, 6, -1);
  endtask

  task automatic testScale();
    phaseIdx = 1; slotPhase = 8'd2;
    playByte("R5", 8'hC3, 3'd1, 3'd2, 20, -1);
    phaseIdx = 2; slotPhase = 8'd4;
    playByte("R5", 8'h3C, 3'd2, 3'd4, 18, -1);
  endtask

  task automatic testWindow();
    playByte("R8", 8'hF0, 3'd1, 3'd1, 10, 2);
    playByte("R8", 8'h77, 3'd4, 3'd2, 6, 0);
  endtask

  task automatic testOddCodes();
    playByte("R9", 8'hB1, 3'd3, 3'd1, 10, -1);
    playByte("R9", 8'h4E, 3'd1, 3'd5, 10, -1);
  endtask

  task automatic testReload();
    playByte("R10", 8'hFF, 3'd1, 3'd1, 3, -1);
    playByte("R10", 8'h0F, 3'd2, 3'd1, 6, -1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDepth1();
    testDepth2();
    testDepth4();
    testScale();
    testWindow();
    testOddCodes();
    testReload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule